// File: doc/BRIEF.md
# Strobe-gated serial DAC loader

This block is the digital front end that collects a 12-bit conversion word one bit at a time and hands it to the register that drives a converter. Serial data arrives on one pin. A shift happens on one of four strobe pins, and each strobe has its own active edge and its own enable rule. Three strobes act on a rising edge. The fourth acts on a falling edge and also serves as the enable for the other three. The word enters most significant bit first.

The bit leaving the top of the shift register appears on a serial output, so several loaders can be chained. A transfer into the DAC register needs two active-low load pins low together. A separate active-low clear zeroes the DAC register at once, without waiting for a clock.

Every strobe, load and data input passes through a two-stage synchroniser to the system clock. Edges are detected after the synchroniser, so the block accepts strobes that are slow compared with the clock.

Top module: `serdac_loader`

## Requirements
- R1: After reset, `dac_word` is 0 and `sdo` is 0.
- R2: A rising edge on `stb_rise_a`, `stb_rise_b` or `stb_rise_c` shifts one bit only when `stb_fall` is high and the other two rising-edge strobes are both low. Any other rising edge on these three pins leaves the shift register unchanged.
- R3: A falling edge on `stb_fall` shifts one bit only when all three rising-edge strobes are low. A rising edge on `stb_fall` never shifts. A falling edge on any of the three rising-edge strobes never shifts.
- R4: Each accepted shift moves the register one place toward bit 11 and puts `sdi` into bit 0. After 12 shifts, the first bit sent is in bit 11, so a word sent MSB first lands unchanged.
- R5: `sdo` is bit 11 of the shift register and changes only on an accepted shift. While a new word is shifted in, `sdo` presents the previous word from bit 10 down to bit 0, followed by the first new bit.
- R6: While `ld_a_n` and `ld_b_n` are both low, the DAC register copies the shift register on every clock. If either pin is high, `dac_word` holds its value.
- R7: No gap is needed between the last shift and a load. With both load pins held low during shifting, `dac_word` follows each shift in the next clock cycle.
- R8: Driving `clr_n` low zeroes `dac_word` at once, without a clock edge. While `clr_n` is low, loads have no effect. The shift register keeps its contents through a clear, so a load after `clr_n` returns high restores the word that was shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| sdi | input | 1 | Serial data input |
| stb_rise_a | input | 1 | Rising-edge strobe A |
| stb_rise_b | input | 1 | Rising-edge strobe B |
| stb_fall | input | 1 | Falling-edge strobe; its high level enables the rising-edge strobes |
| stb_rise_c | input | 1 | Rising-edge strobe C |
| ld_a_n | input | 1 | First active-low load input |
| ld_b_n | input | 1 | Second active-low load input |
| clr_n | input | 1 | Active-low asynchronous clear of the DAC register |
| sdo | output | 1 | Serial output for chaining (shift register bit 11) |
| dac_word | output | 12 | DAC register contents |

## Verification
The assertions assume that every input holds its level for several clock cycles, so that the synchronised copies of a strobe and of `sdi` describe the same moment. They also assume that `clr_n` never pulses low and back high between two clock edges, since the check on the DAC register's value across cycles samples the clear only at the clock. The stimulus changes inputs on the falling clock edge and waits four cycles after every change. It sets `sdi` before the strobe that captures it, and it holds the clear low for several cycles. Expected values come from a model shift register in the bench. That model is updated only for edges that the rules in R2 and R3 accept.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  localparam int NUM_STB = 4;

  // Position of each strobe in the internal strobe vector.
  typedef enum int {
    STB_RA = 0,
    STB_RB = 1,
    STB_FL = 2,
    STB_RC = 3
  } stb_idx_e;

  // A rising-edge strobe fires when it rises while the gate is high
  // and no sibling rising strobe is high.
  function automatic logic rise_hit(logic now_l, logic prev_l,
                                    logic gate_hi, logic any_sibling);
    return now_l & ~prev_l & gate_hi & ~any_sibling;
  endfunction

  // The falling-edge strobe fires when it drops while all rising strobes are low.
  function automatic logic fall_hit(logic now_l, logic prev_l, logic any_rise);
    return ~now_l & prev_l & ~any_rise;
  endfunction

  // Transfer condition: both active-low load lines asserted.
  function automatic logic load_ok(logic la_n, logic lb_n);
    return ~la_n & ~lb_n;
  endfunction

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/sdl_strobe_qual.sv
module sdl_strobe_qual
  import sdl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_STB-1:0] stb_s,
  output logic [NUM_STB-1:0] hit,
  output logic               shift_en
);

  logic [NUM_STB-1:0] stb_prev;
  logic [NUM_STB-1:0] rise_mask;

  assign rise_mask = ~(NUM_STB'(1) << STB_FL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_prev <= '0;
    else        stb_prev <= stb_s;
  end

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    if (g == STB_FL) begin : g_fall
      assign hit[g] = fall_hit(stb_s[g], stb_prev[g], |(stb_s & rise_mask));
    end else begin : g_rise
      logic [NUM_STB-1:0] sib_mask;
      assign sib_mask = rise_mask & ~(NUM_STB'(1) << g);
      assign hit[g] = rise_hit(stb_s[g], stb_prev[g], stb_s[STB_FL],
                               |(stb_s & sib_mask));
    end
  end

  assign shift_en = |hit;

endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] sr_q,
  output logic         sdo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= {sr_q[W-2:0], din};
  end

  assign sdo = sr_q[W-1];

endmodule

// File: rtl/sdl_dac_reg.sv
module sdl_dac_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dac_q
);

  logic arst_n;
  assign arst_n = rst_n & clr_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      dac_q <= '0;
    else if (load_en) dac_q <= din;
  end

endmodule

// File: rtl/serdac_loader.sv
module serdac_loader
  import sdl_pkg::*;
#(
  parameter int WORD_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              stb_rise_a,
  input  logic              stb_rise_b,
  input  logic              stb_fall,
  input  logic              stb_rise_c,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [WORD_W-1:0] dac_word
);

  localparam int DS_W = NUM_STB + 1;

  logic [NUM_STB-1:0] stb_raw;
  logic [NUM_STB-1:0] stb_s;
  logic [NUM_STB-1:0] stb_hit;
  logic               sdi_s;
  logic [1:0]         ld_s;
  logic               shift_en;
  logic               load_en;
  logic [WORD_W-1:0]  sr_q;

  assign stb_raw[STB_RA] = stb_rise_a;
  assign stb_raw[STB_RB] = stb_rise_b;
  assign stb_raw[STB_FL] = stb_fall;
  assign stb_raw[STB_RC] = stb_rise_c;

  // Data and strobes share one synchroniser so they stay aligned.
  sdl_sync #(.W(DS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_ds (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sdi, stb_raw}),
    .q    ({sdi_s, stb_s})
  );

  // Load lines idle high after reset.
  sdl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_ld (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ld_b_n, ld_a_n}),
    .q    (ld_s)
  );

  sdl_strobe_qual u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_s   (stb_s),
    .hit     (stb_hit),
    .shift_en(shift_en)
  );

  sdl_shift #(.W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .din     (sdi_s),
    .sr_q    (sr_q),
    .sdo     (sdo)
  );

  assign load_en = load_ok(ld_s[0], ld_s[1]);

  sdl_dac_reg #(.W(WORD_W)) u_dac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_n  (clr_n),
    .load_en(load_en),
    .din    (sr_q),
    .dac_q  (dac_word)
  );

endmodule

// File: rtl/serdac_loader_chk.sv
module serdac_loader_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_n,
  input logic         sdi_s,
  input logic         shift_en,
  input logic [3:0]   stb_hit,
  input logic         load_en,
  input logic [W-1:0] sr_q,
  input logic [W-1:0] dac_q,
  input logic         sdo
);

  AST_HOLD_WITHOUT_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q)); // R2

  AST_ONE_STROBE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb_hit)); // R3

  AST_BIT0_TAKES_SDI: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sr_q[0] == $past(sdi_s)); // R4

  AST_SDO_NEXT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> sdo == $past(sr_q[W-2])); // R5

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && clr_n) |=> (!clr_n || dac_q == $past(sr_q))); // R6

  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && clr_n) |=> (!clr_n || $stable(dac_q))); // R6

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_q == '0); // R8

endmodule

bind serdac_loader serdac_loader_chk #(.W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_n   (clr_n),
  .sdi_s   (sdi_s),
  .shift_en(shift_en),
  .stb_hit (stb_hit),
  .load_en (load_en),
  .sr_q    (sr_q),
  .dac_q   (dac_word),
  .sdo     (sdo)
);

// File: tb/serdac_loader_bench.sv
module serdac_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        stb_rise_a = 1'b0, stb_rise_b = 1'b0, stb_fall = 1'b1, stb_rise_c = 1'b0;
  logic        ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
  logic        sdo;
  logic [11:0] dac_word;

  logic [11:0] model_sr = '0;
  logic [11:0] model_dac = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serdac_loader u_serdac_loader (
    .clk(clk), .rst_n(rst_n), .sdi(sdi),
    .stb_rise_a(stb_rise_a), .stb_rise_b(stb_rise_b),
    .stb_fall(stb_fall), .stb_rise_c(stb_rise_c),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
    .sdo(sdo), .dac_word(dac_word)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_shift(logic b);
    model_sr = {model_sr[10:0], b};
  endtask

  task automatic set_strobe(int idx, logic v);
    case (idx)
      0: stb_rise_a = v;
      1: stb_rise_b = v;
      2: stb_fall = v;
      default: stb_rise_c = v;
    endcase
    step(4);
  endtask

  // One accepted shift through strobe idx, starting from the idle state.
  task automatic shift_bit(int idx, logic b);
    sdi = b;
    step(4);
    if (idx == 2) set_strobe(2, 1'b0);
    else          set_strobe(idx, 1'b1);
    model_shift(b);
    check("R5 sdo after shift", {11'd0, sdo}, {11'd0, model_sr[11]});
    if (idx == 2) set_strobe(2, 1'b1);
    else          set_strobe(idx, 1'b0);
  endtask

  task automatic load_check(string tag);
    ld_a_n = 1'b0; ld_b_n = 1'b0;
    step(5);
    model_dac = model_sr;
    check(tag, dac_word, model_dac);
    ld_a_n = 1'b1; ld_b_n = 1'b1;
    step(4);
  endtask

  task automatic send_word(int idx, logic [11:0] w);
    logic [11:0] prev;
    prev = model_sr;
    for (int k = 0; k < 12; k++) begin
      shift_bit(idx, w[11-k]);
      if (k < 11) check("R5 chain previous word", {11'd0, sdo}, {11'd0, prev[10-k]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(6);
    check("R1 dac after reset", dac_word, 12'h000);
    check("R1 sdo after reset", {11'd0, sdo}, 12'h000);

    // Sweep of words over all four strobes.
    for (int w = 0; w < 24; w++) begin
      logic [11:0] word;
      int idx;
      case (w)
        0: word = 12'h000;
        1: word = 12'hFFF;
        2: word = 12'h800;
        3: word = 12'h001;
        default: word = 12'(w * 12'h6B5 + 12'h013);
      endcase
      idx = w % 4;
      send_word(idx, word);
      load_check("R4 word via load");
      check("R4 word lands MSB first", dac_word, word);
    end

    // R6: a single load line does not transfer.
    send_word(0, 12'h5A3);
    load_check("R6 both low loads");
    shift_bit(1, 1'b1);
    ld_a_n = 1'b0; step(5);
    check("R6 only ld_a low holds", dac_word, model_dac);
    ld_a_n = 1'b1; ld_b_n = 1'b0; step(5);
    check("R6 only ld_b low holds", dac_word, model_dac);
    ld_b_n = 1'b1; step(4);
    load_check("R6 both low after single");

    // R2: rising strobe while stb_fall low is ignored.
    sdi = 1'b1; step(4);
    set_strobe(2, 1'b0); model_shift(1'b1);
    sdi = 1'b0; step(4);
    set_strobe(0, 1'b1);
    check("R2 rise with gate low ignored", {11'd0, sdo}, {11'd0, model_sr[11]});
    set_strobe(0, 1'b0);
    set_strobe(2, 1'b1);
    load_check("R2 gate low ignored");

    // R2: rising strobe while a sibling is high is ignored.
    sdi = 1'b1; step(4);
    set_strobe(1, 1'b1); model_shift(1'b1);
    sdi = 1'b0; step(4);
    set_strobe(0, 1'b1);
    set_strobe(3, 1'b1);
    set_strobe(0, 1'b0);
    set_strobe(3, 1'b0);
    set_strobe(1, 1'b0);
    load_check("R2 sibling high ignored");

    // R3: falling strobe while a rising strobe is high is ignored.
    sdi = 1'b0; step(4);
    set_strobe(3, 1'b1); model_shift(1'b0);
    sdi = 1'b1; step(4);
    set_strobe(2, 1'b0);
    set_strobe(3, 1'b0);
    set_strobe(2, 1'b1);
    load_check("R3 fall with rise high ignored");

    // R7: loads held low during shifting, dac follows without gap.
    ld_a_n = 1'b0; ld_b_n = 1'b0; step(4);
    send_word(3, 12'h3C6);
    step(1);
    check("R7 dac follows last shift", dac_word, 12'h3C6);
    ld_a_n = 1'b1; ld_b_n = 1'b1; step(4);
    model_dac = model_sr;

    // R8: asynchronous clear.
    send_word(2, 12'hB19);
    load_check("R8 word before clear");
    clr_n = 1'b0;
    #1;
    check("R8 clear without clock", dac_word, 12'h000);
    step(2);
    ld_a_n = 1'b0; ld_b_n = 1'b0; step(5);
    check("R8 load ignored during clear", dac_word, 12'h000);
    ld_a_n = 1'b1; ld_b_n = 1'b1; step(4);
    clr_n = 1'b1; step(4);
    check("R8 zero after clear release", dac_word, 12'h000);
    load_check("R8 shift register kept through clear");
    check("R8 restored word", dac_word, 12'hB19);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule